// File: doc/BRIEF.md
# Serial Flash Command Engine (SPI Slave)

This block is the device side of a small serial memory reached over a four-wire SPI link in mode 0. MOSI is sampled on the rising SCLK edge and MISO changes after the falling edge, most significant bit first. A system clock oversamples the link pins through synchronizers, so SCLK must stay well below the system clock rate. Bytes are framed by chip select. The first complete byte after select is the operation code. Read and write operations then take a 24-bit address, and after it a data phase that advances the address by one for every byte.

Three operation codes act only on a write-enable flag, which is exposed as bit 1 of a status byte: 0x06 sets the flag, 0x04 clears it and 0x05 reads the status byte back. Writes (0x02) reach the internal array only while the flag is set. Reads (0x03) stream array bytes back. The array index is the low bits of the 24-bit address, so addresses wrap modulo the array depth.

Top module: `spif_engine`

## Requirements
- R1: After reset, MISO is 0, the write-enable flag is clear, and MISO stays 0 whenever chip select is high.
- R2: The first byte after chip select falls is the operation code. MISO returns 0x00 during that byte and during every address byte.
- R3: Opcodes 0x03 and 0x02 are followed by three address bytes, most significant byte first, forming a 24-bit address.
- R4: Opcode 0x03 returns the array byte at the current address during each following byte and then advances the address by one.
- R5: Opcode 0x02 stores each following MOSI byte at the current address and then advances the address by one.
- R6: While the write-enable flag is clear, opcode 0x02 leaves the array unchanged.
- R7: Opcode 0x06 sets the write-enable flag. Opcode 0x05 returns the status byte during every following byte, with the flag in bit 1 and all other bits 0.
- R8: Opcode 0x04 clears the write-enable flag.
- R9: Any other opcode returns 0x00 during every following byte and changes neither the flag nor the array.
- R10: Raising chip select ends the current operation and discards a partly shifted byte. The next complete byte is a new opcode.
- R11: The array index is the 24-bit address modulo the array depth (256 by default). The address advances modulo 2^24, so a stream crosses from the top of the array to index 0.
- R12: MISO bytes are sent most significant bit first, valid before the rising SCLK edge on which the master samples them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_sclk | input | 1 | SPI serial clock from the master (mode 0) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, 0 when deselected |

## Verification
The array is filled through one long write. Directed frames then check bit order (0x80 and 0x01), address byte order (addresses whose high and low bytes differ) and the wrap at the top of both the 24-bit address and the array index. Reads after a write with the flag clear, after unknown opcodes and after aborted frames tell a real store apart from an ignored one. Seeded random frames mix every opcode, address and length against a bench model of the array and the flag, so a wrong increment, a wrong gating by the flag or a stale command across selects shows up as a data mismatch.

// File: rtl/spif_pkg.sv
package spif_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned ADDR_W     = 24;
  localparam int unsigned ADDR_BYTES = ADDR_W / BYTE_W;
  localparam int unsigned WEL_BIT    = 1;

  typedef enum logic [BYTE_W-1:0] {
    OP_WRITE  = 8'h02,
    OP_READ   = 8'h03,
    OP_WRDIS  = 8'h04,
    OP_RDSTAT = 8'h05,
    OP_WREN   = 8'h06
  } opcode_e;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;
endpackage

// File: rtl/spif_sync.sv
module spif_sync #(
  parameter int unsigned       WIDTH     = 1,
  parameter int unsigned       STAGES    = 2,
  parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RESET_VAL}};
    else        pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/spif_byte_io.sv
module spif_byte_io
  import spif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_s,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done,
  output logic              miso
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  bit_cnt_q, bit_cnt_n;
  logic [BYTE_W-1:0] rx_q, rx_n;
  logic [BYTE_W-1:0] tx_q, tx_n;
  logic              last_bit;

  assign last_bit  = (bit_cnt_q == CNT_W'(BYTE_W-1));
  assign rx_byte   = {rx_q[BYTE_W-2:0], mosi_s};
  assign byte_done = active && sclk_rise && last_bit;

  always_comb begin
    bit_cnt_n = bit_cnt_q;
    rx_n      = rx_q;
    tx_n      = tx_q;
    if (!active) begin
      bit_cnt_n = '0;
      rx_n      = '0;
      tx_n      = '0;
    end else begin
      if (sclk_rise) begin
        rx_n      = rx_byte;
        bit_cnt_n = last_bit ? '0 : bit_cnt_q + CNT_W'(1);
      end
      if (tx_load) begin
        tx_n = tx_byte;
      end else if (sclk_fall && bit_cnt_q != '0) begin
        tx_n = {tx_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
    end else begin
      bit_cnt_q <= bit_cnt_n;
      rx_q      <= rx_n;
      tx_q      <= tx_n;
    end
  end

  assign miso = active & tx_q[BYTE_W-1];

  // R10: deselect drops any partly counted byte
  p_desel_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> bit_cnt_q == '0);

  // R12: MISO holds between falling edges while selected
  p_miso_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    active && $past(active) && !sclk_fall && !tx_load && !$past(tx_load) && !$past(sclk_fall)
      |=> $stable(tx_q[BYTE_W-1]));
endmodule

// File: rtl/spif_mem.sv
module spif_mem #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cell_q[waddr] <= wdata;
  end

  assign rdata = cell_q[raddr];
endmodule

// File: rtl/spif_cmd_ctrl.sv
module spif_cmd_ctrl
  import spif_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned LEFT_W = $clog2(ADDR_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              tx_load,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_waddr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [IDX_W-1:0]  mem_raddr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              wel
);
  phase_e             phase_q, phase_n;
  logic [BYTE_W-1:0]  cmd_q, cmd_n;
  logic [ADDR_W-1:0]  addr_q, addr_n, addr_shift;
  logic [LEFT_W-1:0]  left_q, left_n;
  logic               wel_q, wel_n;
  logic [BYTE_W-1:0]  status;
  logic               cmd_known;

  always_comb begin
    status          = '0;
    status[WEL_BIT] = wel_q;
  end

  assign addr_shift = {addr_q[ADDR_W-BYTE_W-1:0], rx_byte};
  assign cmd_known  = (cmd_q == OP_WRITE) || (cmd_q == OP_READ) || (cmd_q == OP_WRDIS) ||
                      (cmd_q == OP_RDSTAT) || (cmd_q == OP_WREN);

  always_comb begin
    phase_n = phase_q;
    cmd_n   = cmd_q;
    addr_n  = addr_q;
    left_n  = left_q;
    wel_n   = wel_q;
    tx_byte = '0;
    mem_we  = 1'b0;
    if (!active) begin
      phase_n = PH_CMD;
      cmd_n   = '0;
    end else if (byte_done) begin
      unique case (phase_q)
        PH_CMD: begin
          cmd_n  = rx_byte;
          addr_n = '0;
          left_n = LEFT_W'(ADDR_BYTES-1);
          case (rx_byte)
            OP_WRITE, OP_READ: phase_n = PH_ADDR;
            OP_WREN: begin
              wel_n   = 1'b1;
              phase_n = PH_DATA;
            end
            OP_WRDIS: begin
              wel_n   = 1'b0;
              phase_n = PH_DATA;
            end
            OP_RDSTAT: begin
              tx_byte = status;
              phase_n = PH_DATA;
            end
            default: phase_n = PH_DATA;
          endcase
        end
        PH_ADDR: begin
          addr_n = addr_shift;
          left_n = left_q - LEFT_W'(1);
          if (left_q == '0) begin
            phase_n = PH_DATA;
            if (cmd_q == OP_READ) begin
              tx_byte = mem_rdata;
              addr_n  = addr_shift + ADDR_W'(1);
            end
          end
        end
        PH_DATA: begin
          case (cmd_q)
            OP_READ: begin
              tx_byte = mem_rdata;
              addr_n  = addr_q + ADDR_W'(1);
            end
            OP_WRITE: begin
              mem_we = wel_q;
              addr_n = addr_q + ADDR_W'(1);
            end
            OP_RDSTAT: tx_byte = status;
            default: ;
          endcase
        end
        default: phase_n = PH_CMD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      cmd_q   <= '0;
      addr_q  <= '0;
      left_q  <= '0;
      wel_q   <= 1'b0;
    end else begin
      phase_q <= phase_n;
      cmd_q   <= cmd_n;
      addr_q  <= addr_n;
      left_q  <= left_n;
      wel_q   <= wel_n;
    end
  end

  assign tx_load   = active & byte_done;
  assign mem_waddr = addr_q[IDX_W-1:0];
  assign mem_wdata = rx_byte;
  assign mem_raddr = (phase_q == PH_ADDR) ? addr_shift[IDX_W-1:0] : addr_q[IDX_W-1:0];
  assign wel       = wel_q;

  // R7: set-enable opcode raises the flag
  p_wren_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    active && byte_done && phase_q == PH_CMD && rx_byte == OP_WREN |=> wel_q);

  // R8: clear-enable opcode drops the flag
  p_wrdis_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active && byte_done && phase_q == PH_CMD && rx_byte == OP_WRDIS |=> !wel_q);

  // R9: unknown opcode leaves the flag alone and never writes
  p_unknown_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active && phase_q == PH_DATA && !cmd_known |-> !mem_we ##1 $stable(wel_q));

  // R4: each data byte of a stream advances the address by one
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active && byte_done && phase_q == PH_DATA && (cmd_q == OP_READ || cmd_q == OP_WRITE)
      |=> addr_q == $past(addr_q) + ADDR_W'(1));

  // R10: deselect returns to the opcode phase with no command held
  p_desel_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> phase_q == PH_CMD && cmd_q == '0);
endmodule

// File: rtl/spif_engine.sv
module spif_engine
  import spif_pkg::*;
#(
  parameter int unsigned MEM_DEPTH   = 256,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  localparam int unsigned IDX_W = $clog2(MEM_DEPTH);

  logic              rst_int_n;
  logic [2:0]        pins_s;
  logic              sclk_s, cs_n_s, mosi_s;
  logic              sclk_d;
  logic              active, sclk_rise, sclk_fall;
  logic [BYTE_W-1:0] rx_byte, tx_byte, mem_wdata, mem_rdata;
  logic              byte_done, tx_load, mem_we, wel;
  logic [IDX_W-1:0]  mem_waddr, mem_raddr;

  spif_sync #(.WIDTH(1), .STAGES(2), .RESET_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  spif_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b010)) u_pin_sync (
    .clk(clk), .rst_n(rst_int_n), .d({spi_sclk, spi_cs_n, spi_mosi}), .q(pins_s)
  );

  assign {sclk_s, cs_n_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) sclk_d <= 1'b0;
    else            sclk_d <= sclk_s;
  end

  assign active    = ~cs_n_s;
  assign sclk_rise = active & sclk_s & ~sclk_d;
  assign sclk_fall = active & ~sclk_s & sclk_d;

  spif_byte_io u_byte_io (
    .clk(clk), .rst_n(rst_int_n), .active(active),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s),
    .tx_load(tx_load), .tx_byte(tx_byte),
    .rx_byte(rx_byte), .byte_done(byte_done), .miso(spi_miso)
  );

  spif_cmd_ctrl #(.DEPTH(MEM_DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .active(active),
    .byte_done(byte_done), .rx_byte(rx_byte),
    .tx_load(tx_load), .tx_byte(tx_byte),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .wel(wel)
  );

  spif_mem #(.DEPTH(MEM_DEPTH), .WIDTH(BYTE_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  // R1: MISO is low whenever the device is deselected
  p_idle_miso_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    cs_n_s |-> !spi_miso);

  // R6: no array write happens while the flag is clear
  p_we_needs_wel_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_we |-> wel);
endmodule

// File: tb/spif_engine_test.sv
`timescale 1ns/1ps
module spif_engine_test;
  localparam int DEPTH = 256;
  localparam int HALF  = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, sclk, cs_n, mosi;
  wire  miso;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model_mem [DEPTH];
  logic       model_wel;

  spif_engine uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso)
  );

  function automatic logic [7:0] exp_status();
    return {6'b0, model_wel, 1'b0};
  endfunction

  function automatic logic [7:0] exp_read(logic [23:0] a);
    return model_mem[a[7:0]];
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
  endtask

  task automatic partial(input logic [7:0] tx, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic desel();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic send_hdr(logic [7:0] op, logic [23:0] a);
    logic [7:0] rx;
    xfer(op, rx);
    chk("R2 opcode reply", rx, 8'h00);
    for (int b = 2; b >= 0; b--) begin
      xfer(a[b*8 +: 8], rx);
      chk("R2 address reply", rx, 8'h00);
    end
  endtask

  task automatic do_flag(logic [7:0] op);
    logic [7:0] rx;
    sel();
    xfer(op, rx);
    desel();
    if (op == 8'h06) model_wel = 1'b1;
    if (op == 8'h04) model_wel = 1'b0;
  endtask

  task automatic rd_status(string req);
    logic [7:0] rx;
    sel();
    xfer(8'h05, rx);
    chk("R2 opcode reply", rx, 8'h00);
    xfer(8'h00, rx);
    chk(req, rx, exp_status());
    xfer(8'hFF, rx);
    chk(req, rx, exp_status());
    desel();
  endtask

  task automatic do_write(logic [23:0] a, int n, logic [7:0] first);
    logic [7:0] rx, d;
    sel();
    send_hdr(8'h02, a);
    for (int i = 0; i < n; i++) begin
      d = (i == 0) ? first : 8'($urandom);
      xfer(d, rx);
      if (model_wel) model_mem[8'(a + 24'(i))] = d;
    end
    desel();
  endtask

  task automatic do_read(logic [23:0] a, int n, string req);
    logic [7:0] rx;
    sel();
    send_hdr(8'h03, a);
    for (int i = 0; i < n; i++) begin
      xfer(8'($urandom), rx);
      chk(req, rx, exp_read(a + 24'(i)));
    end
    desel();
  endtask

  task automatic do_unknown(logic [7:0] op, int n);
    logic [7:0] rx;
    sel();
    xfer(op, rx);
    chk("R2 opcode reply", rx, 8'h00);
    for (int i = 0; i < n; i++) begin
      xfer(8'($urandom), rx);
      chk("R9 unknown reply", rx, 8'h00);
    end
    desel();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rx, op;
    logic [23:0] a;
    int kind, n;
    void'($urandom(32'd2024));
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0;
    model_wel = 1'b0;
    for (int i = 0; i < DEPTH; i++) model_mem[i] = 8'h00;
    wait_clk(10);
    chk("R1 miso in reset", {7'b0, miso}, 8'h00);
    rst_n = 1'b1;
    wait_clk(10);
    chk("R1 miso after reset", {7'b0, miso}, 8'h00);
    rd_status("R1 status after reset");

    // R7 then R5: fill the whole array
    do_flag(8'h06);
    rd_status("R7 flag set");
    do_write(24'h000000, DEPTH, 8'h3C);
    do_read(24'h000000, 8, "R5 stored data");

    // R12 bit order
    do_write(24'h000010, 1, 8'h80);
    do_write(24'h000011, 1, 8'h01);
    do_read(24'h000010, 2, "R12 bit order");

    // R3 address byte order
    do_write(24'h123440, 1, 8'h5A);
    do_read(24'h000040, 1, "R3 address MSB first");
    do_read(24'h403412, 1, "R3 address MSB first");

    // R11 wrap
    do_read(24'hFFFFFE, 4, "R11 wrap 24-bit");
    do_write(24'h0001FF, 3, 8'hC3);
    do_read(24'h0000FF, 3, "R11 wrap index");

    // R8 then R6
    do_flag(8'h04);
    rd_status("R8 flag cleared");
    do_write(24'h000020, 4, 8'hE7);
    do_read(24'h000020, 4, "R6 write ignored");

    // R9
    do_flag(8'h06);
    do_unknown(8'hA7, 3);
    rd_status("R9 flag unchanged");
    do_unknown(8'h00, 2);
    do_read(24'h000010, 2, "R9 array unchanged");

    // R10: aborted read, then new opcode
    sel();
    send_hdr(8'h03, 24'h000005);
    xfer(8'h00, rx);
    desel();
    rd_status("R10 new command after deselect");
    do_flag(8'h04);
    sel();
    partial(8'h06, 7);
    desel();
    rd_status("R10 partial byte discarded");

    // R4 long stream
    do_flag(8'h06);
    do_read(24'h0000F0, 20, "R4 read stream");

    // random mix
    for (int it = 0; it < 30; it++) begin
      kind = int'($urandom_range(0, 5));
      a    = 24'($urandom);
      n    = int'($urandom_range(1, 8));
      case (kind)
        0: do_write(a, n, 8'($urandom));
        1: do_read(a, n, "R4 random read");
        2: do_flag(8'h06);
        3: do_flag(8'h04);
        4: rd_status("R7 random status");
        default: begin
          op = 8'($urandom) | 8'h80;
          do_unknown(op, n);
        end
      endcase
    end
    do_read(24'h000000, 16, "R5 final readback");
    finish_run();
  end
endmodule